// File: doc/BRIEF.md
# Pin-Level Flash Programming Sequencer

This block runs on the host side and programs the on-chip flash of a small microcontroller through its parallel programming pins. After a `start` pulse it brings the target into programming mode. It then takes code bytes one at a time from a valid/ready stream and writes each one in turn. Every byte is verified before the next one is taken. The raised programming voltage on the target's reset pin is shown only as the digital output `pin_hv_en`. An external level shifter is expected to turn that output into the actual voltage.

The target has no address input. Its internal address counter is cleared when reset rises and advances by one on each positive pulse of the target clock pin. The sequencer therefore keeps its own copy of that count. It orders every pin change so that data and mode lines are settled before the high voltage is applied, and the high voltage is on before the strobe pulse. Each write ends when the target's ready line returns high. The byte is then read back under read mode and compared. The address advances only after a successful compare.

Every pin change is separated from the previous one by at least `GAP_CYC` system clocks. Pulses last `PULSE_CYC` clocks. A session ends in one of four ways: after the byte flagged last, after a full array of `2**ADDR_W` bytes, on a verify mismatch, or when ready stays low for longer than `TIMEOUT_CYC`. All four exits run the same power-down order.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset and before any `start`, every target pin output is low, and `in_ready`, `done`, `err_mismatch` and `err_timeout` are low.
- R2: On `start`, the sequencer holds reset and target clock low, then raises reset, then raises the strobe. `in_ready` is only ever high with reset and strobe high and the high-voltage enable low.
- R3: For each byte, the data lines carry the byte with the output enable set, and the mode lines carry the write code (`pin_mode` = 4'b1110, i.e. line 0 low, lines 1 to 3 high). This happens before `pin_hv_en` rises. The strobe then goes low for one pulse, and only while `pin_hv_en` is high.
- R4: After the strobe returns high, `pin_hv_en` stays high until `pin_ready` is seen high. The only exception is the timeout path.
- R5: Verify drops `pin_hv_en` first. It then sets the read code (`pin_mode` = 4'b1100, lines 0 and 1 low, lines 2 and 3 high) with the data output enable off, and compares `pin_data_in` with the written byte.
- R6: After each successful verify, exactly one positive pulse appears on `pin_xclk`. During the pulse, the high-voltage enable and the data output enable are both low.
- R7: The session ends after the byte marked with `in_last`, or after `2**ADDR_W` bytes, whichever comes first. No further byte is accepted. Power-down brings the target clock low before reset falls, and `done` is then raised.
- R8: On a verify mismatch, `err_mismatch` is set and held, and `err_addr` gives the failing address. No clock pulse or further byte follows, and power-down runs.
- R9: If `pin_ready` is still low `TIMEOUT_CYC` clocks after the strobe rises, `err_timeout` is set, `err_addr` gives the address, `pin_hv_en` drops at once, and power-down runs.
- R10: Any two changes on the target pin outputs are at least `GAP_CYC` clocks apart.
- R11: A `start` while idle or done clears both error flags and the internal address. A new session then programs from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a programming session when idle or done |
| in_valid | input | 1 | Code byte available |
| in_data | input | DATA_W | Code byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Sequencer takes the byte this cycle |
| pin_rst | output | 1 | Target reset pin at logic-high level |
| pin_hv_en | output | 1 | Raise target reset pin to programming voltage |
| pin_xclk | output | 1 | Target clock pin, advances the target address |
| pin_strobe | output | 1 | Target program strobe, active-low pulse |
| pin_mode | output | 4 | Mode lines, bit 0 is the lowest-numbered line |
| pin_data_out | output | DATA_W | Data driven toward the target port |
| pin_data_oe | output | 1 | Output enable for `pin_data_out` |
| pin_data_in | input | DATA_W | Data read from the target port |
| pin_ready | input | 1 | Target ready (high) / busy (low) |
| done | output | 1 | Session finished and target powered down |
| err_mismatch | output | 1 | Sticky verify-mismatch flag |
| err_timeout | output | 1 | Sticky ready-timeout flag |
| err_addr | output | ADDR_W | Address at which an error was flagged |

## Verification
The bench drives a behavioural target that tracks its own address from the reset and clock edges, holds ready low for a fixed time after each strobe, and can corrupt one read-back address or leave ready stuck low. The single-byte stream checks that the first byte is not lost between power-up and fetch. A full array without any last marker shows whether the sequencer stops at the array boundary or wraps and overwrites address 0. A corrupted read-back tests whether a design advances the clock anyway, which would shift every later byte by one address. A stuck ready line catches a sequencer that hangs with the high voltage applied. A restart after an error catches error flags or an address count left over from the failed session.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PU_LOW,
    ST_PU_RST,
    ST_PU_PROG,
    ST_FETCH,
    ST_WR_SETUP,
    ST_HV_ON,
    ST_STROBE,
    ST_STROBE_END,
    ST_WAIT_RDY,
    ST_HV_OFF,
    ST_RD_SETUP,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_PD_HV,
    ST_PD_CLK,
    ST_PD_RST,
    ST_DONE
  } fps_state_e;

  localparam logic [3:0] MODE_IDLE  = 4'b0000;
  localparam logic [3:0] MODE_WRITE = 4'b1110;
  localparam logic [3:0] MODE_READ  = 4'b1100;

  // States whose hold time is a pulse width rather than a setup gap.
  function automatic logic is_pulse_state(input fps_state_e s);
    return (s == ST_STROBE) || (s == ST_CLK_HI);
  endfunction

  // Target reset pin held at logic high.
  function automatic logic rst_high(input fps_state_e s);
    return !(s == ST_IDLE || s == ST_PU_LOW || s == ST_PD_RST || s == ST_DONE);
  endfunction

  function automatic logic hv_phase(input fps_state_e s);
    return s == ST_HV_ON || s == ST_STROBE || s == ST_STROBE_END || s == ST_WAIT_RDY;
  endfunction

  function automatic logic write_phase(input fps_state_e s);
    return s == ST_WR_SETUP || hv_phase(s) || s == ST_HV_OFF || s == ST_PD_HV;
  endfunction

  function automatic logic read_phase(input fps_state_e s);
    return s == ST_RD_SETUP || s == ST_CLK_HI || s == ST_CLK_LO;
  endfunction

  function automatic logic drive_phase(input fps_state_e s);
    return s == ST_WR_SETUP || hv_phase(s) || s == ST_PD_HV;
  endfunction

endpackage

// File: rtl/fps_hold_timer.sv
module fps_hold_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fps_ready_watchdog.sv
module fps_ready_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic hit
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit = (cnt_q >= CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm) begin
      cnt_q <= '0;
    end else if (!hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fps_addr_counter.sv
module fps_addr_counter #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          at_top
);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (clr) begin
      addr_q <= '0;
    end else if (inc) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr   = addr_q;
  assign at_top = (addr_q == {AW{1'b1}});

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 10,
  parameter int GAP_CYC     = 4,
  parameter int PULSE_CYC   = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              pin_rst,
  output logic              pin_hv_en,
  output logic              pin_xclk,
  output logic              pin_strobe,
  output logic [3:0]        pin_mode,
  output logic [DATA_W-1:0] pin_data_out,
  output logic              pin_data_oe,
  input  logic [DATA_W-1:0] pin_data_in,
  input  logic              pin_ready,
  output logic              done,
  output logic              err_mismatch,
  output logic              err_timeout,
  output logic [ADDR_W-1:0] err_addr
);

  localparam int HOLD_MAX = (GAP_CYC > PULSE_CYC) ? GAP_CYC : PULSE_CYC;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

  fps_state_e state_q, state_d;
  logic [DATA_W-1:0] byte_q;
  logic              last_q;
  logic              err_mm_q, err_to_q;
  logic [ADDR_W-1:0] err_addr_q;

  logic              tmr_done, tmr_load;
  logic [HOLD_W-1:0] tmr_val;
  logic              to_hit, to_arm;
  logic [ADDR_W-1:0] addr;
  logic              at_top;

  // Named internal events, visible to the checker.
  logic ev_start, ev_accept, ev_mismatch, ev_timeout, ev_advance;

  assign ev_start    = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign ev_accept   = (state_q == ST_FETCH) && in_valid;
  assign ev_mismatch = (state_q == ST_RD_SETUP) && tmr_done && (pin_data_in != byte_q);
  assign ev_timeout  = (state_q == ST_WAIT_RDY) && !pin_ready && to_hit;
  assign ev_advance  = (state_q == ST_CLK_LO) && tmr_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (ev_start) state_d = ST_PU_LOW;
      ST_PU_LOW:     if (tmr_done) state_d = ST_PU_RST;
      ST_PU_RST:     if (tmr_done) state_d = ST_PU_PROG;
      ST_PU_PROG:    if (tmr_done) state_d = ST_FETCH;
      ST_FETCH:      if (ev_accept) state_d = ST_WR_SETUP;
      ST_WR_SETUP:   if (tmr_done) state_d = ST_HV_ON;
      ST_HV_ON:      if (tmr_done) state_d = ST_STROBE;
      ST_STROBE:     if (tmr_done) state_d = ST_STROBE_END;
      ST_STROBE_END: if (tmr_done) state_d = ST_WAIT_RDY;
      ST_WAIT_RDY: begin
        if (pin_ready)       state_d = ST_HV_OFF;
        else if (ev_timeout) state_d = ST_PD_HV;
      end
      ST_HV_OFF:     if (tmr_done) state_d = ST_RD_SETUP;
      ST_RD_SETUP: begin
        if (ev_mismatch)   state_d = ST_PD_CLK;
        else if (tmr_done) state_d = ST_CLK_HI;
      end
      ST_CLK_HI:     if (tmr_done) state_d = ST_CLK_LO;
      ST_CLK_LO: begin
        if (ev_advance) state_d = (last_q || at_top) ? ST_PD_CLK : ST_FETCH;
      end
      ST_PD_HV:      if (tmr_done) state_d = ST_PD_CLK;
      ST_PD_CLK:     if (tmr_done) state_d = ST_PD_RST;
      ST_PD_RST:     if (tmr_done) state_d = ST_DONE;
      ST_DONE:       if (ev_start) state_d = ST_PU_LOW;
      default:       state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = is_pulse_state(state_d) ? HOLD_W'(PULSE_CYC - 1) : HOLD_W'(GAP_CYC - 1);

  fps_hold_timer #(.W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign to_arm = (state_q == ST_STROBE_END) || (state_q == ST_WAIT_RDY);

  fps_ready_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (to_arm),
    .hit   (to_hit)
  );

  fps_addr_counter #(.AW(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ev_start),
    .inc    (ev_advance),
    .addr   (addr),
    .at_top (at_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      byte_q     <= '0;
      last_q     <= 1'b0;
      err_mm_q   <= 1'b0;
      err_to_q   <= 1'b0;
      err_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        err_mm_q   <= 1'b0;
        err_to_q   <= 1'b0;
        err_addr_q <= '0;
        last_q     <= 1'b0;
      end
      if (ev_accept) begin
        byte_q <= in_data;
        last_q <= in_last;
      end
      if (ev_mismatch) begin
        err_mm_q   <= 1'b1;
        err_addr_q <= addr;
      end
      if (ev_timeout) begin
        err_to_q   <= 1'b1;
        err_addr_q <= addr;
      end
    end
  end

  // Pin drive, decoded from the registered state only.
  assign pin_rst      = rst_high(state_q);
  assign pin_strobe   = rst_high(state_q) && (state_q != ST_PU_RST) && (state_q != ST_STROBE);
  assign pin_hv_en    = hv_phase(state_q);
  assign pin_xclk     = (state_q == ST_CLK_HI);
  assign pin_data_oe  = drive_phase(state_q);
  assign pin_data_out = pin_data_oe ? byte_q : '0;

  always_comb begin
    if (write_phase(state_q))
      pin_mode = MODE_WRITE;
    else if (read_phase(state_q) || (state_q == ST_FETCH && addr != '0))
      pin_mode = MODE_READ;
    else
      pin_mode = MODE_IDLE;
  end

  assign in_ready     = (state_q == ST_FETCH);
  assign done         = (state_q == ST_DONE);
  assign err_mismatch = err_mm_q;
  assign err_timeout  = err_to_q;
  assign err_addr     = err_addr_q;

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int DATA_W  = 8,
  parameter int GAP_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_ready,
  input logic              pin_rst,
  input logic              pin_hv_en,
  input logic              pin_xclk,
  input logic              pin_strobe,
  input logic [3:0]        pin_mode,
  input logic [DATA_W-1:0] pin_data_out,
  input logic              pin_data_oe,
  input logic              pin_ready,
  input logic              err_mismatch,
  input logic              err_timeout,
  input logic              ev_mismatch,
  input logic              ev_timeout
);

  localparam int PW = DATA_W + 9;
  localparam int CW = $clog2(GAP_CYC + 1);

  logic [PW-1:0] pins_now, pins_q;
  logic [CW-1:0] since_q;
  logic          chg;

  assign pins_now = {pin_rst, pin_hv_en, pin_xclk, pin_strobe, pin_mode, pin_data_oe, pin_data_out};
  assign chg      = (pins_now != pins_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= '0;
      since_q <= CW'(GAP_CYC);
    end else begin
      pins_q <= pins_now;
      if (chg)
        since_q <= '0;
      else if (since_q < CW'(GAP_CYC))
        since_q <= since_q + 1'b1;
    end
  end

  AST_READY_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (pin_rst && pin_strobe && !pin_hv_en)); // R2

  AST_HV_NEEDS_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hv_en |-> (pin_data_oe && pin_mode == 4'b1110 && pin_rst)); // R3

  AST_STROBE_UNDER_HV: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin_strobe) && pin_rst) |-> pin_hv_en); // R3

  AST_HV_HELD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_hv_en) |-> ($past(pin_ready) || err_timeout)); // R4

  AST_XCLK_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_xclk |-> (!pin_hv_en && !pin_data_oe && pin_mode == 4'b1100)); // R6

  AST_RST_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_rst) |-> (!pin_xclk && !$past(pin_xclk))); // R7

  AST_MISMATCH_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> (err_mismatch && !pin_xclk)); // R8

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mismatch && !start) |=> err_mismatch); // R8

  AST_TIMEOUT_DROPS_HV: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (err_timeout && !pin_hv_en)); // R9

  AST_PIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (since_q >= CW'(GAP_CYC - 1))); // R10

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .DATA_W  (DATA_W),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .in_ready     (in_ready),
  .pin_rst      (pin_rst),
  .pin_hv_en    (pin_hv_en),
  .pin_xclk     (pin_xclk),
  .pin_strobe   (pin_strobe),
  .pin_mode     (pin_mode),
  .pin_data_out (pin_data_out),
  .pin_data_oe  (pin_data_oe),
  .pin_ready    (pin_ready),
  .err_mismatch (err_mismatch),
  .err_timeout  (err_timeout),
  .ev_mismatch  (ev_mismatch),
  .ev_timeout   (ev_timeout)
);

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int NB = 1 << AW;
  localparam int BUSY_CYC = 10;
  localparam logic [3:0] WR_CODE = 4'b1110;
  localparam logic [3:0] RD_CODE = 4'b1100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready;
  logic pin_rst, pin_hv_en, pin_xclk, pin_strobe, pin_data_oe;
  logic [3:0] pin_mode;
  logic [DW-1:0] pin_data_out, pin_data_in;
  logic pin_ready;
  logic done, err_mismatch, err_timeout;
  logic [AW-1:0] err_addr;

  always #5 clk = ~clk;

  flash_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .pin_rst(pin_rst), .pin_hv_en(pin_hv_en), .pin_xclk(pin_xclk), .pin_strobe(pin_strobe),
    .pin_mode(pin_mode), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
    .pin_data_in(pin_data_in), .pin_ready(pin_ready),
    .done(done), .err_mismatch(err_mismatch), .err_timeout(err_timeout), .err_addr(err_addr)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural target ----------------
  logic [DW-1:0] mem [0:NB-1];
  logic [DW-1:0] src [0:NB];
  logic [AW-1:0] maddr;
  logic [DW-1:0] wlatch;
  logic [AW-1:0] waddr;
  logic m_rst, m_xclk, m_strobe;
  logic model_clr = 1'b0;
  int bcnt;
  int nwrites;
  int stuck_at = -1;
  int corrupt_at = -1;

  always @(posedge clk) begin
    m_rst    <= pin_rst;
    m_xclk   <= pin_xclk;
    m_strobe <= pin_strobe;
    if (model_clr) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
      bcnt      <= 0;
      pin_ready <= 1'b1;
      nwrites   <= 0;
      maddr     <= '0;
    end else begin
      if (pin_rst && !m_rst) maddr <= '0;
      else if (pin_xclk && !m_xclk) maddr <= maddr + 1'b1;
      if (pin_strobe && !m_strobe && pin_hv_en && pin_mode == WR_CODE) begin
        wlatch <= pin_data_out;
        waddr  <= maddr;
        bcnt   <= 1;
      end else if (bcnt > 0) begin
        if (bcnt == 2) pin_ready <= 1'b0;
        if (bcnt >= BUSY_CYC + 2) begin
          if (int'(waddr) != stuck_at) begin
            mem[waddr] <= wlatch;
            nwrites    <= nwrites + 1;
            pin_ready  <= 1'b1;
            bcnt       <= 0;
          end
        end else begin
          bcnt <= bcnt + 1;
        end
      end
    end
  end

  assign pin_data_in = (pin_mode == RD_CODE && !pin_hv_en && pin_rst)
                       ? (mem[maddr] ^ ((int'(maddr) == corrupt_at) ? 8'h01 : 8'h00))
                       : 8'hFF;

  // ---------------- pin monitor (samples at negedge) ----------------
  logic p_rst = 1'b0, p_hv = 1'b0, p_xclk = 1'b0, p_strobe = 1'b0, p_ready = 1'b1;
  int n_strobe = 0;
  int n_xclk = 0;
  int cyc = 0;
  int rst_rise_cyc = 0;
  int strobe_rise_cyc = 0;
  logic [AW-1:0] mon_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (model_clr) begin
      n_strobe = 0;
      n_xclk   = 0;
    end
    if (pin_rst && !p_rst) begin
      rst_rise_cyc = cyc;
      mon_addr     = '0;
    end
    if (pin_strobe && !p_strobe && pin_rst && !pin_hv_en && n_strobe == 0) strobe_rise_cyc = cyc;
    if (!pin_strobe && p_strobe && pin_rst) begin
      n_strobe++;
      chk(pin_hv_en && pin_data_oe && pin_mode == WR_CODE, "R3", "strobe fell without hv/write setup",
          {pin_hv_en, pin_data_oe, pin_mode}, {1'b1, 1'b1, WR_CODE});
      chk(pin_data_out == src[mon_addr], "R3", "data on port at strobe", pin_data_out, src[mon_addr]);
    end
    if (!pin_hv_en && p_hv) begin
      chk(p_ready || err_timeout, "R4", "hv dropped while busy", p_ready, 1);
    end
    if (pin_xclk && !p_xclk) begin
      n_xclk++;
      mon_addr = mon_addr + 1'b1;
      chk(!pin_hv_en && !pin_data_oe && pin_mode == RD_CODE, "R5", "read mode at clock pulse",
          {pin_hv_en, pin_data_oe, pin_mode}, {1'b0, 1'b0, RD_CODE});
    end
    if (!pin_rst && p_rst) begin
      chk(!pin_xclk && !p_xclk, "R7", "target clock low before reset falls", p_xclk, 0);
    end
    p_rst = pin_rst; p_hv = pin_hv_en; p_xclk = pin_xclk; p_strobe = pin_strobe; p_ready = pin_ready;
  end

  // ---------------- helpers ----------------
  int fed_cnt = 0;

  task automatic clear_model();
    @(negedge clk); model_clr = 1'b1;
    @(negedge clk); model_clr = 1'b0;
  endtask

  task automatic feed(input int n, input bit use_last);
    fed_cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = src[i];
      in_last  = use_last && (i == n - 1);
      while (!in_ready && !done) @(negedge clk);
      if (done) break;
      if (i == 0) begin
        chk(pin_rst && pin_strobe && !pin_xclk && !pin_hv_en, "R2", "pins at first fetch",
            {pin_rst, pin_strobe, pin_xclk, pin_hv_en}, 4'b1100);
        chk(rst_rise_cyc < strobe_rise_cyc, "R2", "reset rose before strobe",
            rst_rise_cyc, strobe_rise_cyc);
      end
      @(posedge clk);
      fed_cnt++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    int c = 0;
    while (!done && c < limit) begin
      @(negedge clk);
      c++;
    end
    chk(done, "R7", "session reached done", done, 1);
  endtask

  task automatic run(input int n, input bit use_last, input int limit);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    fork
      feed(n, use_last);
      wait_done(limit);
    join
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk({pin_rst, pin_hv_en, pin_xclk, pin_strobe, pin_data_oe} == 5'b0 && pin_mode == 4'b0,
        "R1", "pins after reset", {pin_rst, pin_hv_en, pin_xclk, pin_strobe, pin_mode}, 0);
    chk(!in_ready && !done && !err_mismatch && !err_timeout, "R1", "flags after reset",
        {in_ready, done, err_mismatch, err_timeout}, 0);
  endtask

  task automatic t_stream(input int n, input int seed);
    int bad = 0;
    clear_model();
    for (int i = 0; i < n; i++) src[i] = DW'(seed + i * 37);
    run(n, 1'b1, 20000);
    for (int i = 0; i < n; i++) if (mem[i] != src[i]) bad++;
    chk(bad == 0, "R3", "bytes stored in target", bad, 0);
    chk(n_xclk == n, "R6", "clock pulses per byte", n_xclk, n);
    chk(fed_cnt == n && !in_ready, "R7", "stream stops after last", fed_cnt, n);
    chk(!err_mismatch && !err_timeout && !pin_rst, "R7", "clean power-down",
        {err_mismatch, err_timeout, pin_rst}, 0);
  endtask

  task automatic t_alt();
    int bad = 0;
    clear_model();
    for (int i = 0; i < 4; i++) src[i] = i[0] ? 8'hAA : 8'h55;
    run(4, 1'b1, 20000);
    for (int i = 0; i < 4; i++) if (mem[i] != src[i]) bad++;
    chk(bad == 0, "R5", "alternating pattern verified", bad, 0);
  endtask

  task automatic t_full();
    int bad = 0;
    clear_model();
    for (int i = 0; i <= NB; i++) src[i] = DW'(i * 7 + 3);
    run(NB + 1, 1'b0, 120000);
    for (int i = 0; i < NB; i++) if (mem[i] != src[i]) bad++;
    chk(fed_cnt == NB, "R7", "full array stops at boundary", fed_cnt, NB);
    chk(bad == 0 && nwrites == NB, "R7", "full array contents", bad, 0);
    chk(n_xclk == NB, "R6", "clock pulses over full array", n_xclk, NB);
  endtask

  task automatic t_mismatch();
    clear_model();
    corrupt_at = 2;
    for (int i = 0; i < 6; i++) src[i] = DW'(8'h10 + i);
    run(6, 1'b1, 20000);
    chk(err_mismatch && !err_timeout, "R8", "mismatch flag", {err_mismatch, err_timeout}, 2'b10);
    chk(err_addr == 2, "R8", "mismatch address", err_addr, 2);
    chk(fed_cnt == 3 && n_xclk == 2, "R8", "halted at failing byte", {fed_cnt, n_xclk}, {32'd3, 32'd2});
    repeat (20) @(negedge clk);
    chk(err_mismatch && !pin_rst && !in_ready, "R8", "flag held after stop",
        {err_mismatch, pin_rst, in_ready}, 3'b100);
    corrupt_at = -1;
  endtask

  task automatic t_timeout();
    clear_model();
    stuck_at = 1;
    for (int i = 0; i < 4; i++) src[i] = DW'(8'hC0 + i);
    run(4, 1'b1, 20000);
    chk(err_timeout && !err_mismatch, "R9", "timeout flag", {err_timeout, err_mismatch}, 2'b10);
    chk(err_addr == 1, "R9", "timeout address", err_addr, 1);
    chk(fed_cnt == 2 && n_xclk == 1 && !pin_hv_en, "R9", "stopped with hv off",
        {fed_cnt, n_xclk}, {32'd2, 32'd1});
    stuck_at = -1;
  endtask

  task automatic t_restart();
    clear_model();
    src[0] = 8'h3C; src[1] = 8'hC3;
    run(2, 1'b1, 20000);
    chk(!err_timeout && !err_mismatch, "R11", "errors cleared by start",
        {err_timeout, err_mismatch}, 0);
    chk(mem[0] == 8'h3C && mem[1] == 8'hC3, "R11", "restart writes from address 0",
        {mem[0], mem[1]}, 16'h3CC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_stream(5, 1);
    t_stream(1, 200);
    t_alt();
    t_mismatch();
    t_timeout();
    t_restart();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule